// File: doc/BRIEF.md
# Parallel Radix-8 Decimation-in-Frequency Butterfly

This block computes a complete 8-point discrete Fourier transform on every clock cycle. Eight complex samples arrive side by side on wide buses and are processed by a fully unrolled decimation-in-frequency network. The network has three levels of add/subtract pairs, with four pairs per level. Between the levels sit the fixed internal rotations. Multiplying by -j costs only rewiring and one negation. The two diagonal rotations by e^(-jπ/4) and e^(-j3π/4) each use a single quantised constant, 1/√2.

The block is meant as the arithmetic core of one stage in a wide-lane streaming FFT. It never stalls and has no handshake. A valid flag runs beside the data through the pipeline, so gaps in the input stream show up as gaps at the output. Each adder level widens the datapath by one guard bit, so nothing overflows inside the block. The final result is divided by eight with round-to-nearest and then clamped back to the input wordlength. The outputs leave in bit-reversed frequency order.

Top module: `r8bf_top`

## Requirements
- R1: A new set of eight complex samples is accepted on every cycle in which `in_valid` is high, with no stall. `out_valid` repeats `in_valid` exactly 3 cycles later, including any gaps, and each output set belongs to the input set taken 3 cycles earlier.
- R2: Reset is synchronous and active high. While reset is applied, `out_valid` and both output buses read zero on the cycle that follows.
- R3: Lane p occupies bits [p*W +: W] of each bus; the real part is on `*_re` and the imaginary part on `*_im`. Output lane p carries frequency bin bitrev3(p), where bin k is the sum over n of x[n]·e^(-j2πnk/8). So lanes 0..7 hold bins 0,4,2,6,1,5,3,7.
- R4: Each output equals its frequency bin divided by 8 and rounded to nearest, within 1 LSB. When all eight input lanes hold the same value v, lane 0 gives exactly v and every other lane gives exactly zero.
- R5: The e^(-jπ/4) and e^(-j3π/4) rotations use the constant round(2^CF/√2) and round to nearest. Single-lane impulse inputs, which exercise these rotations, meet the 1 LSB bound of R4.
- R6: An all-zero input set produces an all-zero output set exactly.
- R7: A scaled result outside the W-bit range is clamped to 2^(W-1)-1 or -2^(W-1). It never wraps.
- R8: The wordlength W is a parameter. Instances with W=8 and W=16 meet R1 to R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks the input set as valid on this cycle |
| in_re | input | 8*W | Real parts of the eight input samples, lane n at [n*W +: W] |
| in_im | input | 8*W | Imaginary parts of the eight input samples |
| out_valid | output | 1 | Marks the output set as valid, 3 cycles after input |
| out_re | output | 8*W | Real parts of the scaled bins, bit-reversed lane order |
| out_im | output | 8*W | Imaginary parts of the scaled bins |

## Verification
The properties look back three cycles. They assume reset was applied at the start and that the look-back window never reaches into the reset period, so each one is gated until three clean cycles have passed. The exact-value properties (zero input, equal-lane input) take for granted that the data path captures inputs whether or not they are flagged valid. The stimulus changes inputs only between clock edges. It mixes back-to-back sets, sets separated by gaps, a mid-stream reset, and corner patterns that reach the clamp limit from both sides.

// File: rtl/r8bf_pkg.sv
`timescale 1ns/1ps
package r8bf_pkg;
    localparam int LANES    = 8;
    localparam int HALF     = LANES / 2;
    localparam int LAT      = 3;
    localparam int SCALE_SH = 3;

    // internal rotation selected per branch of the flow graph
    typedef enum logic [1:0] {
        ROT_NONE = 2'd0,
        ROT_W1   = 2'd1,
        ROT_MJ   = 2'd2,
        ROT_W3   = 2'd3
    } rot_e;

    // 1/sqrt(2) quantised to cf fraction bits, rounded to nearest
    function automatic int coef(input int cf);
        return $rtoi(0.70710678118654752 * (2.0 ** cf) + 0.5);
    endfunction
endpackage

// File: rtl/r8bf_addsub.sv
`timescale 1ns/1ps
module r8bf_addsub #(
    parameter int IW = 16
) (
    input  logic signed [IW-1:0] a_re,
    input  logic signed [IW-1:0] a_im,
    input  logic signed [IW-1:0] b_re,
    input  logic signed [IW-1:0] b_im,
    output logic signed [IW:0]   s_re,
    output logic signed [IW:0]   s_im,
    output logic signed [IW:0]   d_re,
    output logic signed [IW:0]   d_im
);
    // one guard bit per level: sum and difference never overflow
    assign s_re = (IW+1)'(a_re) + (IW+1)'(b_re);
    assign s_im = (IW+1)'(a_im) + (IW+1)'(b_im);
    assign d_re = (IW+1)'(a_re) - (IW+1)'(b_re);
    assign d_im = (IW+1)'(a_im) - (IW+1)'(b_im);
endmodule

// File: rtl/r8bf_rot.sv
`timescale 1ns/1ps
module r8bf_rot import r8bf_pkg::*; #(
    parameter int   IW   = 16,
    parameter int   OW   = 17,
    parameter int   CF   = 17,
    parameter rot_e MODE = ROT_NONE
) (
    input  logic signed [IW-1:0] re,
    input  logic signed [IW-1:0] im,
    output logic signed [OW-1:0] o_re,
    output logic signed [OW-1:0] o_im
);
    if (MODE == ROT_NONE) begin : g_pass
        assign o_re = OW'(re);
        assign o_im = OW'(im);
    end else if (MODE == ROT_MJ) begin : g_mj
        // (a + jb)(-j) = b - ja : wiring plus one negation
        assign o_re = OW'(im);
        assign o_im = -OW'(re);
    end else begin : g_diag
        localparam int PW = IW + CF + 2;
        localparam logic signed [PW-1:0] KC = PW'(coef(CF));
        localparam logic signed [PW-1:0] RH = PW'(1) <<< (CF - 1);
        logic signed [PW-1:0] sp;
        logic signed [PW-1:0] sm;
        logic signed [PW-1:0] pp;
        logic signed [PW-1:0] pm;
        assign sp = PW'(re) + PW'(im);
        assign sm = PW'(im) - PW'(re);
        assign pp = sp * KC;
        assign pm = sm * KC;
        if (MODE == ROT_W1) begin : g_w1
            // (a + jb)(1 - j)/sqrt2
            assign o_re = OW'((pp + RH) >>> CF);
            assign o_im = OW'((pm + RH) >>> CF);
        end else begin : g_w3
            // (a + jb)(-1 - j)/sqrt2
            assign o_re = OW'((pm + RH) >>> CF);
            assign o_im = OW'((RH - pp) >>> CF);
        end
    end
endmodule

// File: rtl/r8bf_scale.sv
`timescale 1ns/1ps
module r8bf_scale #(
    parameter int IW = 20,
    parameter int OW = 16,
    parameter int SH = 3
) (
    input  logic signed [IW-1:0] v,
    output logic signed [OW-1:0] o
);
    localparam logic signed [IW-1:0] RH = IW'(1) <<< (SH - 1);
    localparam logic signed [IW-1:0] HI = IW'((2 ** (OW - 1)) - 1);
    localparam logic signed [IW-1:0] LO = -IW'(2 ** (OW - 1));

    logic signed [IW-1:0] t;
    assign t = (v + RH) >>> SH;
    assign o = (t > HI) ? OW'(HI) : ((t < LO) ? OW'(LO) : OW'(t));
endmodule

// File: rtl/r8bf_top.sv
`timescale 1ns/1ps
module r8bf_top import r8bf_pkg::*; #(
    parameter int W  = 16,
    parameter int CF = W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [LANES*W-1:0] in_re,
    input  logic [LANES*W-1:0] in_im,
    output logic               out_valid,
    output logic [LANES*W-1:0] out_re,
    output logic [LANES*W-1:0] out_im
);
    localparam int W1 = W + 2;   // after level 1 and its rotations
    localparam int W2 = W + 3;   // after level 2
    localparam int W3 = W + 4;   // after level 3, before scaling

    typedef struct packed { logic signed [W-1:0]  re; logic signed [W-1:0]  im; } c0_t;
    typedef struct packed { logic signed [W1-1:0] re; logic signed [W1-1:0] im; } c1_t;
    typedef struct packed { logic signed [W2-1:0] re; logic signed [W2-1:0] im; } c2_t;

    c0_t x [LANES];
    c1_t s1_d [LANES];
    c1_t s1_q [LANES];
    c2_t s2_d [LANES];
    c2_t s2_q [LANES];
    c0_t o_d [LANES];
    c0_t o_q [LANES];
    logic [LAT-1:0] vld;

    for (genvar p = 0; p < LANES; p++) begin : g_io
        assign x[p].re = in_re[p*W +: W];
        assign x[p].im = in_im[p*W +: W];
        assign out_re[p*W +: W] = o_q[p].re;
        assign out_im[p*W +: W] = o_q[p].im;
    end

    // level 1: pairs (n, n+4), difference rotated by W8^n
    for (genvar n = 0; n < HALF; n++) begin : g_l1
        logic signed [W:0] sr, si, dr, di;
        r8bf_addsub #(.IW(W)) u_bf (
            .a_re(x[n].re), .a_im(x[n].im),
            .b_re(x[n+HALF].re), .b_im(x[n+HALF].im),
            .s_re(sr), .s_im(si), .d_re(dr), .d_im(di)
        );
        r8bf_rot #(.IW(W+1), .OW(W1), .CF(CF), .MODE(ROT_NONE)) u_sum (
            .re(sr), .im(si), .o_re(s1_d[n].re), .o_im(s1_d[n].im)
        );
        r8bf_rot #(.IW(W+1), .OW(W1), .CF(CF), .MODE(rot_e'(n))) u_tw (
            .re(dr), .im(di), .o_re(s1_d[n+HALF].re), .o_im(s1_d[n+HALF].im)
        );
    end

    // level 2: pairs (a, a+2) in each half, difference rotated by -j when odd
    for (genvar g = 0; g < 2; g++) begin : g_l2
        for (genvar i = 0; i < 2; i++) begin : g_pair
            localparam int A = g * HALF + i;
            localparam int B = A + 2;
            logic signed [W2-1:0] sr, si, dr, di;
            r8bf_addsub #(.IW(W1)) u_bf (
                .a_re(s1_q[A].re), .a_im(s1_q[A].im),
                .b_re(s1_q[B].re), .b_im(s1_q[B].im),
                .s_re(sr), .s_im(si), .d_re(dr), .d_im(di)
            );
            assign s2_d[A].re = sr;
            assign s2_d[A].im = si;
            r8bf_rot #(.IW(W2), .OW(W2), .CF(CF),
                       .MODE((i == 0) ? ROT_NONE : ROT_MJ)) u_tw (
                .re(dr), .im(di), .o_re(s2_d[B].re), .o_im(s2_d[B].im)
            );
        end
    end

    // level 3: adjacent pairs, then divide by 8 with rounding and clamp
    for (genvar j = 0; j < HALF; j++) begin : g_l3
        logic signed [W3-1:0] sr, si, dr, di;
        r8bf_addsub #(.IW(W2)) u_bf (
            .a_re(s2_q[2*j].re), .a_im(s2_q[2*j].im),
            .b_re(s2_q[2*j+1].re), .b_im(s2_q[2*j+1].im),
            .s_re(sr), .s_im(si), .d_re(dr), .d_im(di)
        );
        r8bf_scale #(.IW(W3), .OW(W), .SH(SCALE_SH)) u_sc_sr (.v(sr), .o(o_d[2*j].re));
        r8bf_scale #(.IW(W3), .OW(W), .SH(SCALE_SH)) u_sc_si (.v(si), .o(o_d[2*j].im));
        r8bf_scale #(.IW(W3), .OW(W), .SH(SCALE_SH)) u_sc_dr (.v(dr), .o(o_d[2*j+1].re));
        r8bf_scale #(.IW(W3), .OW(W), .SH(SCALE_SH)) u_sc_di (.v(di), .o(o_d[2*j+1].im));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld  <= '0;
            s1_q <= '{default: '0};
            s2_q <= '{default: '0};
            o_q  <= '{default: '0};
        end else begin
            vld  <= {vld[LAT-2:0], in_valid};
            s1_q <= s1_d;
            s2_q <= s2_d;
            o_q  <= o_d;
        end
    end

    assign out_valid = vld[LAT-1];
endmodule

// File: rtl/r8bf_chk.sv
`timescale 1ns/1ps
module r8bf_chk import r8bf_pkg::*; #(
    parameter int W = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic [LANES*W-1:0] in_re,
    input logic [LANES*W-1:0] in_im,
    input logic               out_valid,
    input logic [LANES*W-1:0] out_re,
    input logic [LANES*W-1:0] out_im
);
    // cycles since reset released, saturating at the pipeline depth
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst)              age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    logic same;
    always_comb begin
        same = 1'b1;
        for (int p = 1; p < LANES; p++) begin
            if (in_re[p*W +: W] != in_re[W-1:0] || in_im[p*W +: W] != in_im[W-1:0])
                same = 1'b0;
        end
    end

    a_r2_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && out_re == '0 && out_im == '0));

    a_r1_valid_latency: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    a_r6_zero_in_zero_out: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && $past(in_re == '0 && in_im == '0, 3))
        |-> (out_re == '0 && out_im == '0));

    a_r4_flat_input: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && $past(same, 3))
        |-> (out_re[W-1:0] == $past(in_re[W-1:0], 3) &&
             out_im[W-1:0] == $past(in_im[W-1:0], 3) &&
             out_re[LANES*W-1:W] == '0 && out_im[LANES*W-1:W] == '0));
endmodule

bind r8bf_top r8bf_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
);

// File: tb/tb_r8bf_top.sv
`timescale 1ns/1ps
module tb_r8bf_top;
    localparam int W  = 16;
    localparam int WN = 8;
    localparam real PI = 3.14159265358979324;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [8*W-1:0]  in_re = '0, in_im = '0;
    logic [8*WN-1:0] n_re = '0, n_im = '0;
    logic out_valid, n_valid;
    logic [8*W-1:0]  out_re, out_im;
    logic [8*WN-1:0] no_re, no_im;

    always #5 clk = ~clk;

    r8bf_top #(.W(W)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
        .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
    );
    r8bf_top #(.W(WN)) dut_n (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_re(n_re), .in_im(n_im),
        .out_valid(n_valid), .out_re(no_re), .out_im(no_im)
    );

    int total = 0, bad = 0, cyc = 0;
    bit done = 1'b0;
    int xr[8], xi[8];
    int q_wr[$], q_wi[$], q_nr[$], q_ni[$], q_cyc[$], q_tol[$];
    string q_tag[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int lane(input logic [8*W-1:0] bus, input int p, input int w);
        logic signed [W-1:0] t;
        logic signed [WN-1:0] tn;
        if (w == W) begin t = bus[p*W +: W]; return int'(t); end
        tn = bus[p*WN +: WN];
        return int'(tn);
    endfunction

    // behavioural DFT reference: bin k / 8, rounded, clamped, lanes bit-reversed
    function automatic void model(input int w, input int ar[8], input int ai[8],
                                  output int er[8], output int ei[8]);
        for (int p = 0; p < 8; p++) begin
            int k;
            real sr, si;
            k = ((p & 1) << 2) | (p & 2) | ((p >> 2) & 1);
            sr = 0.0; si = 0.0;
            for (int n = 0; n < 8; n++) begin
                real a;
                a = 2.0 * PI * real'(n * k) / 8.0;
                sr += real'(ar[n]) * $cos(a) + real'(ai[n]) * $sin(a);
                si += real'(ai[n]) * $cos(a) - real'(ar[n]) * $sin(a);
            end
            er[p] = $rtoi($floor(sr / 8.0 + 0.5));
            ei[p] = $rtoi($floor(si / 8.0 + 0.5));
            if (er[p] > (1 << (w-1)) - 1) er[p] = (1 << (w-1)) - 1;
            if (er[p] < -(1 << (w-1)))    er[p] = -(1 << (w-1));
            if (ei[p] > (1 << (w-1)) - 1) ei[p] = (1 << (w-1)) - 1;
            if (ei[p] < -(1 << (w-1)))    ei[p] = -(1 << (w-1));
        end
    endfunction

    task automatic put(input string tag, input int tol);
        int er[8], ei[8], nr[8], ni[8], a8[8], b8[8];
        for (int n = 0; n < 8; n++) begin
            a8[n] = xr[n] >>> 8;
            b8[n] = xi[n] >>> 8;
            in_re[n*W +: W]  = W'(xr[n]);
            in_im[n*W +: W]  = W'(xi[n]);
            n_re[n*WN +: WN] = WN'(a8[n]);
            n_im[n*WN +: WN] = WN'(b8[n]);
        end
        model(W, xr, xi, er, ei);
        model(WN, a8, b8, nr, ni);
        for (int p = 0; p < 8; p++) begin
            q_wr.push_back(er[p]); q_wi.push_back(ei[p]);
            q_nr.push_back(nr[p]); q_ni.push_back(ni[p]);
        end
        q_cyc.push_back(cyc); q_tag.push_back(tag); q_tol.push_back(tol);
        in_valid = 1'b1;
        @(negedge clk);
    endtask

    task automatic idle();
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    function automatic int sg(input real v);
        if (v > 1.0e-9) return 1;
        if (v < -1.0e-9) return -1;
        return 0;
    endfunction

    function automatic bit near(input int a, input int e, input int tol);
        return (a - e <= tol) && (e - a <= tol);
    endfunction

    // compare on every clock against the queued reference
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_valid) begin
                if (q_cyc.size() == 0) begin
                    chk(1'b0, "R1", "unexpected out_valid", 1, 0);
                end else begin
                    int c, tol;
                    string tag;
                    c = q_cyc.pop_front(); tag = q_tag.pop_front(); tol = q_tol.pop_front();
                    chk(cyc - c == 3, "R1", "latency", cyc - c, 3);
                    chk(n_valid == 1'b1, "R8", "narrow out_valid", int'(n_valid), 1);
                    for (int p = 0; p < 8; p++) begin
                        int er, ei, nr, ni;
                        er = q_wr.pop_front(); ei = q_wi.pop_front();
                        nr = q_nr.pop_front(); ni = q_ni.pop_front();
                        chk(near(lane(out_re, p, W), er, tol), tag, $sformatf("lane %0d re", p), lane(out_re, p, W), er);
                        chk(near(lane(out_im, p, W), ei, tol), tag, $sformatf("lane %0d im", p), lane(out_im, p, W), ei);
                        chk(near(lane(no_re, p, WN), nr, tol), "R8", $sformatf("W8 lane %0d re", p), lane(no_re, p, WN), nr);
                        chk(near(lane(no_im, p, WN), ni, tol), "R8", $sformatf("W8 lane %0d im", p), lane(no_im, p, WN), ni);
                    end
                end
            end else if (q_cyc.size() > 0 && cyc - q_cyc[0] >= 3) begin
                chk(1'b0, "R1", "missing out_valid", 0, 1);
                void'(q_cyc.pop_front()); void'(q_tag.pop_front()); void'(q_tol.pop_front());
                for (int p = 0; p < 8; p++) begin
                    void'(q_wr.pop_front()); void'(q_wi.pop_front());
                    void'(q_nr.pop_front()); void'(q_ni.pop_front());
                end
            end
        end
    end

    task automatic clear_x();
        for (int n = 0; n < 8; n++) begin xr[n] = 0; xi[n] = 0; end
    endtask

    task automatic rand_x();
        for (int n = 0; n < 8; n++) begin
            xr[n] = int'($urandom % 65536) - 32768;
            xi[n] = int'($urandom % 65536) - 32768;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R2: reset state
        chk(out_valid == 1'b0 && n_valid == 1'b0, "R2", "out_valid in reset", int'(out_valid), 0);
        chk(out_re == '0 && out_im == '0, "R2", "outputs in reset", int'(out_re[W-1:0]), 0);
        rst = 1'b0;

        clear_x(); put("R6", 0);                                  // R6 zero in
        for (int n = 0; n < 8; n++) begin xr[n] = 1234; xi[n] = -777; end
        put("R4", 0);                                             // R4 flat input
        clear_x(); xr[1] = 12000; put("R5", 1);                   // R5 impulse, W8^1/W8^3 paths
        clear_x(); xr[3] = 5000; xi[3] = -9000; put("R5", 1);
        for (int n = 0; n < 8; n++) begin                         // R3 tone at bin 3 -> lane 6
            xr[n] = $rtoi(20000.0 * $cos(2.0 * PI * 3.0 * n / 8.0));
            xi[n] = $rtoi(20000.0 * $sin(2.0 * PI * 3.0 * n / 8.0));
        end
        put("R3", 1);
        for (int n = 0; n < 8; n++) begin                         // R7 clamp high and low
            xr[n] = 32767 * sg($cos(PI * n / 4.0));
            xi[n] = 32767 * sg($sin(PI * n / 4.0));
        end
        put("R7", 1);
        for (int n = 0; n < 8; n++) begin xr[n] = -xr[n]; xi[n] = -xi[n]; end
        put("R7", 1);

        repeat (40) begin rand_x(); put("R1", 1); end             // R1 back-to-back stream
        repeat (8) begin rand_x(); put("R1", 1); idle(); idle(); end  // R1 gaps
        repeat (6) idle();

        rand_x(); put("R1", 1); rand_x(); put("R1", 1);
        rst = 1'b1; in_valid = 1'b0;                              // R2 mid-stream reset
        q_wr.delete(); q_wi.delete(); q_nr.delete(); q_ni.delete();
        q_cyc.delete(); q_tag.delete(); q_tol.delete();
        @(negedge clk);
        chk(out_valid == 1'b0 && n_valid == 1'b0, "R2", "out_valid after reset", int'(out_valid), 0);
        chk(out_re == '0 && out_im == '0, "R2", "outputs after reset", int'(out_re[W-1:0]), 0);
        rst = 1'b0;
        repeat (5) idle();

        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL R1 watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule